// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block runs one serial NOR flash transaction for each command that software issues through a small word-addressed register window. Software first loads an opcode register and an address register. For a program-type command it also fills a bank of 32-bit buffer words. It then writes one configuration word whose bit 0 launches the command. The engine selects one of four chip selects and shifts out the opcode, then an optional three-byte address, then optional dummy bytes. After that it moves the data bytes to or from the buffer over 1, 2 or 4 lanes.

The launch bit also serves as the busy flag: reading it back gives 1 until the command has fully ended. Completion, together with two fault pulses from an external protection checker, lands in a nine-bit raw status word. A mask register and a write-one-to-clear register sit over that word, and an interrupt line reports any unmasked raw bit. Register word indices: 0 configuration, 1 opcode (bits 7:0), 2 address (bits 23:0), 3 raw status, 4 masked status, 5 mask, 6 clear. When the top address bit is 1, the low address bits index the buffer.

Top module: `sfc_cmd_engine`

## Requirements
- R1: The opcode, address, mask and buffer words read back what was written. A configuration write made while idle stores bits 19:1. Configuration bit fields are: 0 start, 2:1 chip select, 3 address enable, 6:4 dummy byte count, 7 data enable, 8 direction (1 = read from flash), 16:9 byte count minus one, 19:17 lane mode.
- R2: Configuration bit 0 reads 1 from the cycle after a write with bit 0 set until the command ends, then reads 0. Any configuration write made while busy is ignored: it alters neither the running command nor the stored fields.
- R3: A command sends the 8-bit opcode, then three address bytes (bits 23:16 first) if address enable is set, then the dummy bytes, then the data. Every byte goes out most significant bit first.
- R4: The lane mode gives the opcode-address-data widths: 0→1-1-1, 1→1-1-2, 2→1-2-2, 3→2-2-2, 5→1-1-4, 6→1-4-4, 7→4-4-4, and 4 behaves as 1-1-1. Width 1 drives lane 0 and samples lane 1. Width 2 uses lanes 1:0 and width 4 uses lanes 3:0, with the higher lane carrying the more significant bit.
- R5: Each dummy byte lasts 8/w serial clocks, where w is the address-phase width. All lane enables are 0 during dummy clocks.
- R6: When data enable is set, exactly byte count + 1 data bytes move. When it is clear, no data clocks occur, whatever the count and direction fields hold. During read data all lane enables are 0.
- R7: Transfer byte k maps to buffer word k/4, bits 8*(k mod 4)+7 down to 8*(k mod 4), for both program data and read data.
- R8: The serial clock idles low. Its period is 2*2^DIV_LOG2 system clocks. Outputs change only after a falling edge, and input lanes are sampled on the rising edge.
- R9: During a command, exactly one chip select, the one chosen by the chip select field, is low and stays stable. It rises at least one serial clock period before the busy flag clears.
- R10: Raw status bit 0 sets when a command ends. Bit 2 sets on fault_in[0] and bit 5 sets on fault_in[1]. The other raw bits read 0, and all raw bits are 0 after reset.
- R11: Masked status equals raw AND mask, the mask resets to 0, and irq is high exactly when any masked bit is 1.
- R12: Writing 1s to the clear register clears the matching raw bits. A source event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register or buffer write strobe |
| bus_addr | input | ADDR_W | Word address; top bit selects the buffer |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fault_in | input | 2 | Fault pulses: [0] program error, [1] protected address |
| irq | output | 1 | Interrupt, any unmasked raw status bit |
| sck | output | 1 | Serial clock, mode 0 |
| cs_n | output | 4 | Active-low chip selects |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The bound checker watches the bus-facing invariants on every cycle. It checks that at most one chip select is active and that it stays steady through a command. It also checks that the clock and lane enables are quiet while no device is selected, that the select is released before busy falls, and that completion is flagged as busy falls. Only the bench scenarios can show the lane-by-lane content of each mode: opcode, address, dummy and data bits against a flash model, the byte placement in the buffer, the ignored mid-command launch, and the masking, clearing and set-over-clear order of the status logic.

// File: rtl/sfc_cmd_engine.sv
module sfc_cmd_engine #(
  parameter int BUF_WORDS = 64,
  parameter int DIV_LOG2  = 1,
  parameter int ADDR_W    = $clog2(BUF_WORDS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        fault_in,
  output logic              irq,
  output logic              sck,
  output logic [3:0]        cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);
  localparam int IW = $clog2(BUF_WORDS);

  typedef enum logic [2:0] {S_IDLE, S_OP, S_ADR, S_DUM, S_DAT, S_TAIL, S_GAP} st_t;

  logic [19:1] cfg_q;
  logic        busy_q;
  logic [7:0]  op_q;
  logic [23:0] adr_q;
  logic [8:0]  raw_q, msk_q;
  logic [31:0] buf_q [BUF_WORDS];

  st_t                 st, nst;
  logic [DIV_LOG2-1:0] hc;
  logic                sck_q, gap_q;
  logic [3:0]          bitc, w, wo, wa, wd, lm, ov;
  logic [7:0]          bcnt, plen, obyte, ibyte, rxb, fbyte, nbyte;

  wire       is_buf = bus_addr[ADDR_W-1];
  wire [2:0] ridx   = bus_addr[2:0];
  wire       reg_wr = bus_wr && !is_buf;
  wire       cfg_start_wr = reg_wr && ridx == 3'd0 && bus_wdata[0];
  wire       cfg_wr = reg_wr && ridx == 3'd0 && !busy_q;
  wire       start  = cfg_wr && bus_wdata[0];

  wire [2:0] mode = cfg_q[19:17];
  wire [1:0] sel  = cfg_q[2:1];
  wire       aen  = cfg_q[3];
  wire [2:0] dum  = cfg_q[6:4];
  wire       den  = cfg_q[7];
  wire       rd   = cfg_q[8];
  wire [7:0] cnt  = cfg_q[16:9];

  wire half_tick = &hc;
  wire in_xfer   = st == S_OP || st == S_ADR || st == S_DUM || st == S_DAT;
  wire fall      = in_xfer && half_tick && sck_q;
  wire last_bit  = (bitc + w) == 4'd8;
  wire last_byte = bcnt == plen;
  wire done      = st == S_GAP && half_tick && gap_q;

  wire [7:0]    nb     = bcnt + 8'd1;
  wire [IW-1:0] nwi    = IW'(nb[7:2]);
  wire          rx_we  = fall && last_bit && st == S_DAT && rd;
  wire [IW-1:0] rx_wi  = IW'(bcnt[7:2]);
  wire [1:0]    rx_ln  = bcnt[1:0];

  always_comb begin
    wo = (mode == 3'd3) ? 4'd2 : (mode == 3'd7) ? 4'd4 : 4'd1;
    wa = (mode == 3'd2 || mode == 3'd3) ? 4'd2 : (mode == 3'd6 || mode == 3'd7) ? 4'd4 : 4'd1;
    wd = (mode == 3'd0 || mode == 3'd4) ? 4'd1 : (mode[2] ? 4'd4 : 4'd2);
    case (st)
      S_OP:         w = wo;
      S_ADR, S_DUM: w = wa;
      S_DAT:        w = wd;
      default:      w = 4'd1;
    endcase
    case (st)
      S_ADR:   plen = 8'd2;
      S_DUM:   plen = {5'd0, dum} - 8'd1;
      S_DAT:   plen = cnt;
      default: plen = 8'd0;
    endcase
  end

  always_comb begin
    case (st)
      S_OP:    nst = aen ? S_ADR : (dum != 3'd0) ? S_DUM : den ? S_DAT : S_TAIL;
      S_ADR:   nst = (dum != 3'd0) ? S_DUM : den ? S_DAT : S_TAIL;
      S_DUM:   nst = den ? S_DAT : S_TAIL;
      default: nst = S_TAIL;
    endcase
    case (nst)
      S_ADR:   fbyte = adr_q[23:16];
      S_DAT:   fbyte = rd ? 8'd0 : buf_q[0][7:0];
      default: fbyte = 8'd0;
    endcase
    case (st)
      S_ADR:   nbyte = (bcnt == 8'd0) ? adr_q[15:8] : adr_q[7:0];
      S_DAT:   nbyte = rd ? 8'd0 : buf_q[nwi][8*nb[1:0] +: 8];
      default: nbyte = 8'd0;
    endcase
    case (w)
      4'd4:    rxb = {ibyte[3:0], io_in[3:0]};
      4'd2:    rxb = {ibyte[5:0], io_in[1:0]};
      default: rxb = {ibyte[6:0], io_in[1]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      busy_q <= 1'b0;
      hc     <= '0;
      sck_q  <= 1'b0;
      gap_q  <= 1'b0;
      bitc   <= '0;
      bcnt   <= '0;
      obyte  <= '0;
      ibyte  <= '0;
    end else begin
      hc <= busy_q ? hc + 1'b1 : '0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_OP;
          busy_q <= 1'b1;
          obyte  <= op_q;
          bitc   <= '0;
          bcnt   <= '0;
        end
        S_TAIL: if (half_tick) begin
          st    <= S_GAP;
          gap_q <= 1'b0;
        end
        S_GAP: if (half_tick) begin
          if (gap_q) begin
            st     <= S_IDLE;
            busy_q <= 1'b0;
          end else gap_q <= 1'b1;
        end
        default: if (half_tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            ibyte <= rxb;
          end else begin
            sck_q <= 1'b0;
            if (last_bit) begin
              bitc <= '0;
              if (last_byte) begin
                st    <= nst;
                bcnt  <= '0;
                obyte <= fbyte;
              end else begin
                bcnt  <= nb;
                obyte <= nbyte;
              end
            end else begin
              bitc  <= bitc + w;
              obyte <= obyte << w;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      op_q  <= '0;
      adr_q <= '0;
      msk_q <= '0;
      raw_q <= '0;
    end else begin
      if (cfg_wr) cfg_q <= bus_wdata[19:1];
      if (reg_wr && ridx == 3'd1) op_q  <= bus_wdata[7:0];
      if (reg_wr && ridx == 3'd2) adr_q <= bus_wdata[23:0];
      if (reg_wr && ridx == 3'd5) msk_q <= bus_wdata[8:0];
      raw_q <= (raw_q & ~((reg_wr && ridx == 3'd6) ? bus_wdata[8:0] : 9'd0))
             | {3'd0, fault_in[1], 2'd0, fault_in[0], 1'b0, done};
    end
  end

  always_ff @(posedge clk) begin
    if (bus_wr && is_buf) buf_q[bus_addr[IW-1:0]] <= bus_wdata;
    if (rx_we) buf_q[rx_wi][8*rx_ln +: 8] <= ibyte;
  end

  always_comb begin
    if (is_buf) bus_rdata = buf_q[bus_addr[IW-1:0]];
    else case (ridx)
      3'd0:    bus_rdata = {12'd0, cfg_q, busy_q};
      3'd1:    bus_rdata = {24'd0, op_q};
      3'd2:    bus_rdata = {8'd0, adr_q};
      3'd3:    bus_rdata = {23'd0, raw_q};
      3'd4:    bus_rdata = {23'd0, raw_q & msk_q};
      3'd5:    bus_rdata = {23'd0, msk_q};
      default: bus_rdata = 32'd0;
    endcase
  end

  assign lm = (w == 4'd4) ? 4'hF : (w == 4'd2) ? 4'h3 : 4'h1;
  assign ov = (w == 4'd4) ? obyte[7:4] : (w == 4'd2) ? {2'd0, obyte[7:6]} : {3'd0, obyte[7]};

  assign irq    = |(raw_q & msk_q);
  assign sck    = sck_q;
  assign cs_n   = (st != S_IDLE && st != S_GAP) ? ~(4'b0001 << sel) : 4'hF;
  assign io_oe  = (st == S_OP || st == S_ADR || (st == S_DAT && !rd)) ? lm : 4'h0;
  assign io_out = ov & io_oe;
endmodule

// File: rtl/sfc_cmd_engine_chk.sv
module sfc_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic [3:0] cs_n,
  input logic [3:0] io_oe,
  input logic       busy,
  input logic       raw_done
);
  p_one_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  p_cs_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && !$past(&cs_n)) |-> $stable(cs_n));

  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> (!sck && io_oe == 4'h0));

  p_cs_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_n) |-> busy);

  p_cs_before_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(&cs_n));

  p_done_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> raw_done);
endmodule

bind sfc_cmd_engine sfc_cmd_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sck      (sck),
  .cs_n     (cs_n),
  .io_oe    (io_oe),
  .busy     (busy_q),
  .raw_done (raw_q[0])
);

// File: tb/sim_sfc_cmd_engine.sv
module sim_sfc_cmd_engine;
  localparam int AW   = 7;
  localparam int BUFB = 64;
  localparam int HALF = 2;
  localparam int NCAP = 1100;
  localparam int NV   = 12;
  // {config word without start, opcode, address}
  localparam logic [63:0] VEC [NV] = '{
    {32'h00000000, 8'h06, 24'h000000},
    {32'h00000788, 8'h03, 24'h123456},
    {32'h00000A88, 8'h02, 24'h00ABCD},
    {32'h00020E98, 8'h3B, 24'h654321},
    {32'h00040998, 8'hBB, 24'h0F0F0F},
    {32'h00060488, 8'hA2, 24'h800001},
    {32'h000A1198, 8'h6B, 24'h13579B},
    {32'h000C07B8, 8'hEB, 24'hFEDCBA},
    {32'h000E0CA8, 8'h32, 24'h2468AC},
    {32'h00080286, 8'h9F, 24'h000000},
    {32'h00000F08, 8'h05, 24'h111111},
    {32'h000FFF98, 8'hEC, 24'hC0FFEE}
  };

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [1:0] fault_in = '0;
  logic irq, sck;
  logic [3:0] cs_n, io_out, io_oe, fl_in = '0;

  sfc_cmd_engine u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_in(fault_in), .irq(irq),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(fl_in));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, ncap = 0, ne = 0;
  logic [7:0] cap [NCAP];
  logic [7:0] exq [NCAP];
  realtime capt [2];
  logic [3:0] cs_seen;
  bit reported = 0;
  wire act = ~&cs_n;

  function automatic logic [3:0] pat(int n);
    return 4'(n * 5 + (n >> 3) + 3);
  endfunction
  function automatic logic [31:0] wpat(int i);
    return (32'(i) * 32'h0B1D2F41) ^ 32'hC3A55A3C;
  endfunction

  always @(posedge act) begin ncap = 0; fl_in = pat(0); end
  always @(posedge sck) begin
    if (ncap < NCAP) cap[ncap] = {io_oe, io_out};
    if (ncap < 2) capt[ncap] = $realtime;
    cs_seen = cs_n;
    ncap++;
  end
  always @(negedge sck) fl_in = pat(ncap);

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act_v, input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act_v, exp_v);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk); bus_addr = AW'(a); #1 d = bus_rdata;
  endtask

  task automatic emit(input logic [7:0] b, input int w, input bit drv);
    for (int j = 0; j < 8 / w; j++) begin
      logic [7:0] s = b << (j * w);
      logic [3:0] v = (w == 4) ? s[7:4] : (w == 2) ? {2'd0, s[7:6]} : {3'd0, s[7]};
      logic [3:0] m = (w == 4) ? 4'hF : (w == 2) ? 4'h3 : 4'h1;
      exq[ne] = drv ? {m, v} : 8'h00;
      ne++;
    end
  endtask

  task automatic run_vec(input logic [63:0] v, input bit inject);
    logic [31:0] cfg = v[63:32], r;
    logic [7:0] op = v[31:24];
    logic [23:0] ad = v[23:0];
    int mode = int'(cfg[19:17]), dum = int'(cfg[6:4]), cnt = int'(cfg[16:9]);
    bit aen = cfg[3], den = cfg[7], dir = cfg[8];
    int wo = (mode == 3) ? 2 : (mode == 7) ? 4 : 1;
    int wa = (mode == 2 || mode == 3) ? 2 : (mode >= 6) ? 4 : 1;
    int wd = (mode == 0 || mode == 4) ? 1 : (mode >= 5) ? 4 : 2;
    int dstart, mism = 0, first = -1, it = 0, csup = -1, bz = -1;
    bit seen_low = 0;
    if (den && !dir)
      for (int i = 0; i <= cnt / 4; i++) bus_write(BUFB + i, wpat(i));
    bus_write(1, {24'd0, op});
    bus_write(2, {8'd0, ad});
    bus_write(0, cfg | 32'h1);
    bus_read(0, r);
    chk(r[0] == 1'b1, "R2", "busy flag after launch", 64'(r[0]), 64'd1);
    if (inject) begin
      repeat (20) @(negedge clk);
      bus_write(0, 32'h00000001);
    end
    while (it < 8000) begin
      bus_read(0, r);
      if (!(&cs_n)) seen_low = 1;
      if (seen_low && (&cs_n) && csup < 0) csup = it;
      if (!r[0]) begin bz = it; break; end
      it++;
    end
    // expected stream (R3 R4 R5 R6 R7)
    ne = 0;
    emit(op, wo, 1);
    if (aen) begin emit(ad[23:16], wa, 1); emit(ad[15:8], wa, 1); emit(ad[7:0], wa, 1); end
    for (int d = 0; d < dum; d++) emit(8'h00, wa, 0);
    dstart = ne;
    if (den)
      for (int k = 0; k <= cnt; k++) begin
        logic [31:0] wv = wpat(k / 4);
        emit(dir ? 8'h00 : wv[8*(k%4) +: 8], wd, !dir);
      end
    chk(ncap == ne, "R6", "serial clock count", 64'(ncap), 64'(ne));
    for (int n = 0; n < ne && n < NCAP; n++)
      if (cap[n] !== exq[n]) begin mism++; if (first < 0) first = n; end
    chk(mism == 0, "R3 R4 R5", $sformatf("lane stream beat %0d", first),
        (first >= 0) ? 64'(cap[first]) : 64'd0, (first >= 0) ? 64'(exq[first]) : 64'd0);
    chk(cs_seen == ~(4'b0001 << cfg[2:1]), "R9", "chip select pattern",
        64'(cs_seen), 64'(~(4'b0001 << cfg[2:1])));
    chk(bz >= 0 && csup >= 0 && bz - csup >= 2 * HALF, "R9", "select release lead",
        64'(bz - csup), 64'(2 * HALF));
    if (den && dir) begin
      int bad = 0;
      logic [7:0] ga = 0, ea = 0;
      for (int k = 0; k <= cnt; k++) begin
        logic [7:0] e = 0;
        for (int j = 0; j < 8 / wd; j++) begin
          logic [3:0] p = pat(dstart + k * (8 / wd) + j);
          e = (wd == 4) ? {e[3:0], p} : (wd == 2) ? {e[5:0], p[1:0]} : {e[6:0], p[1]};
        end
        bus_read(BUFB + k / 4, r);
        if (r[8*(k%4) +: 8] !== e && bad == 0) begin ga = r[8*(k%4) +: 8]; ea = e; end
        if (r[8*(k%4) +: 8] !== e) bad++;
      end
      chk(bad == 0, "R7", "read bytes in buffer", 64'(ga), 64'(ea));
    end
    bus_read(3, r);
    chk(r[8:0] == 9'h001, "R10", "completion raw status", 64'(r[8:0]), 64'h1);
    if (inject) begin
      int nc = ncap;
      bus_read(0, r);
      chk(r == (cfg & 32'h000FFFFE), "R2", "config kept after busy write", 64'(r),
          64'(cfg & 32'h000FFFFE));
      repeat (40) @(negedge clk);
      chk(ncap == nc && (&cs_n), "R2", "no second command", 64'(ncap), 64'(nc));
    end
    bus_write(6, 32'h1FF);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    bus_read(0, r);
    chk(r == 32'd0, "R2", "config after reset", 64'(r), 64'd0);
    bus_read(3, r);
    chk(r == 32'd0, "R10", "raw after reset", 64'(r), 64'd0);
    bus_read(5, r);
    chk(r == 32'd0 && irq == 1'b0, "R11", "mask and irq after reset", 64'(r), 64'd0);
    chk(cs_n == 4'hF && sck == 1'b0 && io_oe == 4'h0, "R8", "bus idle after reset",
        64'({cs_n, sck, io_oe}), 64'({4'hF, 1'b0, 4'h0}));

    bus_write(1, 32'h000000A7);
    bus_write(2, 32'h00ABCDEF);
    bus_write(BUFB + 63, 32'hDEADBEEF);
    bus_read(1, r); chk(r == 32'hA7, "R1", "opcode readback", 64'(r), 64'hA7);
    bus_read(2, r); chk(r == 32'hABCDEF, "R1", "address readback", 64'(r), 64'hABCDEF);
    bus_read(BUFB + 63, r); chk(r == 32'hDEADBEEF, "R1", "buffer readback", 64'(r), 64'hDEADBEEF);
    bus_write(0, 32'h000E0CA8);
    bus_read(0, r); chk(r == 32'h000E0CA8, "R1", "config readback no start", 64'(r), 64'h000E0CA8);
    chk(cs_n == 4'hF, "R2", "no command without start", 64'(cs_n), 64'hF);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i], 1'b0);
      if (i == 0) chk(capt[1] - capt[0] == 2.0 * HALF * 4.0, "R8", "serial clock period",
                      64'(int'(capt[1] - capt[0])), 64'(2 * HALF * 4));
    end
    run_vec(VEC[1], 1'b1);

    // status, mask, clear (R10 R11 R12)
    @(negedge clk); fault_in = 2'b11;
    @(negedge clk); fault_in = 2'b00;
    bus_read(3, r); chk(r == 32'h24, "R10", "fault bits", 64'(r), 64'h24);
    chk(irq == 1'b0, "R11", "masked off irq", 64'(irq), 64'd0);
    bus_write(5, 32'h20);
    bus_read(4, r); chk(r == 32'h20 && irq == 1'b1, "R11", "masked status and irq",
                        64'({irq, r}), 64'({1'b1, 32'h20}));
    bus_write(6, 32'h04);
    bus_read(3, r); chk(r == 32'h20, "R12", "clear one bit", 64'(r), 64'h20);
    bus_write(6, 32'h20);
    bus_read(3, r); chk(r == 32'h0 && irq == 1'b0, "R12", "clear all", 64'({irq, r}), 64'd0);
    @(negedge clk); fault_in = 2'b01; bus_wr = 1; bus_addr = 7'd6; bus_wdata = 32'h04;
    @(negedge clk); fault_in = 2'b00; bus_wr = 0;
    bus_read(3, r); chk(r == 32'h04, "R12", "set beats clear", 64'(r), 64'h04);
    bus_write(5, 32'h01);
    chk(irq == 1'b0, "R11", "irq off for unmasked-only source", 64'(irq), 64'd0);
    bus_write(6, 32'h1FF);
    report();
  end
endmodule